// File: doc/BRIEF.md
# Stream Frame Length Adjuster

This block sits inline on a byte-lane stream path. It forces every frame that passes through to lie between a minimum and a maximum length, counted in bytes. Short frames are extended with zero bytes. Long frames are cut at the maximum, and the rest of the oversize input frame is consumed and thrown away. The two limits are run-time inputs. The block latches them on the first beat of each frame, so a new pair of limits applies from the next frame onward.

When a frame ends, a status record is placed on a separate valid/ready port. The record holds the byte count the frame arrived with, the byte count it left with, and two flags: one for a cut frame and one for an extended frame. The record stays in place until it is taken. If a record is still waiting when the next frame wants to finish, the block stalls that frame's final beat. In-range beats pass straight through with no register stage, so there is no added latency on the data path.

Top module: `flen_adjust`

## Requirements
- R1: A frame whose byte count lies within [min, max] leaves unchanged in data, tkeep, tlast, tid, tdest and tuser, in the same cycle it is presented.
- R2: A frame shorter than min leaves with exactly min bytes. Bytes beyond the input count are 0x00. They first fill the unused lanes of the input's last beat, then go into extra beats whose tkeep sets only the lanes below the min count. tlast is set on the beat that holds byte number min.
- R3: A frame longer than max leaves with exactly max bytes. tlast is set on the beat that holds byte max, and that beat's tkeep is cleared above it. All later input beats of the frame are accepted and produce no output.
- R4: Each frame yields one status record carrying the input byte count and the output byte count.
- R5: The status record flags cut frames (input count above output count) and extended frames (input count below output count). Both flags are clear when the two counts are equal.
- R6: The limits are sampled on the first accepted beat of a frame. A change later in that frame has no effect on it.
- R7: A status record stays stable until st_ready is seen with st_valid. While a record is pending, the final beat of the next frame is held, with s_tready low and m_tvalid low.
- R8: On the final output beat of a cut frame, tuser is forced to the bad-frame value (bit 0 = 1 by default) if any accepted beat of that frame up to the cut carried it. Otherwise tuser passes unchanged.
- R9: Output beats carry the tid and tdest of the input beat. Added zero-byte beats repeat the tid, tdest and tuser of the input's last beat.
- R10: After reset, no output or status is valid, and s_tready follows m_tready.
- Encoding: tkeep bit i marks byte lane i (tdata bits 8i+7..8i). Valid lanes are contiguous from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_min_len | input | LEN_W | minimum frame length in bytes |
| cfg_max_len | input | LEN_W | maximum frame length in bytes (>= min, >= 1) |
| s_tdata | input | DATA_W | input data |
| s_tkeep | input | KEEP_W | input lane valid |
| s_tvalid | input | 1 | input beat valid |
| s_tready | output | 1 | input beat accepted |
| s_tlast | input | 1 | input end of frame |
| s_tid | input | ID_W | input identifier |
| s_tdest | input | DEST_W | input destination |
| s_tuser | input | USER_W | input sideband |
| m_tdata | output | DATA_W | output data |
| m_tkeep | output | KEEP_W | output lane valid |
| m_tvalid | output | 1 | output beat valid |
| m_tready | input | 1 | output beat accepted |
| m_tlast | output | 1 | output end of frame |
| m_tid | output | ID_W | output identifier |
| m_tdest | output | DEST_W | output destination |
| m_tuser | output | USER_W | output sideband |
| st_valid | output | 1 | status record valid |
| st_ready | input | 1 | status record taken |
| st_in_len | output | LEN_W | byte count of the input frame |
| st_out_len | output | LEN_W | byte count of the output frame |
| st_trunc | output | 1 | frame was cut |
| st_pad | output | 1 | frame was extended |

## Verification
In-range and cut beats appear on the output in the same cycle they are presented. Added zero-byte beats follow, one per accepted output cycle. A status record appears on the cycle after the edge that completes the frame. The bench therefore drives stimulus just after a rising edge and samples every handshake and every status value at the falling edge of the same cycle. It collects output bytes and status records as they complete, and compares them with values computed from the lengths and limits once a fixed drain period has passed. The stall case is checked a few falling edges into the blocked final beat, before the status port is released.

// File: rtl/flen_pkg.sv
package flen_pkg;
   typedef enum logic [1:0] {
      ST_PASS = 2'd0,
      ST_DROP = 2'd1,
      ST_PAD  = 2'd2
   } flen_state_e;
endpackage

// File: rtl/flen_keep_count.sv
module flen_keep_count #(
   parameter int KEEP_W = 2,
   localparam int CNT_W = $clog2(KEEP_W + 1)
) (
   input  logic [KEEP_W-1:0] keep,
   output logic [CNT_W-1:0]  count
);
   always_comb begin
      count = '0;
      for (int i = 0; i < KEEP_W; i++)
         count = count + CNT_W'(keep[i]);
   end
endmodule

// File: rtl/flen_lane_mask.sv
module flen_lane_mask #(
   parameter int KEEP_W = 2,
   parameter int LEN_W  = 16
) (
   input  logic [LEN_W-1:0]  base,
   input  logic [LEN_W-1:0]  limit,
   output logic [KEEP_W-1:0] mask
);
   for (genvar g = 0; g < KEEP_W; g++) begin : g_lane
      assign mask[g] = ({1'b0, base} + (LEN_W+1)'(g)) < {1'b0, limit};
   end
endmodule

// File: rtl/flen_stat_slot.sv
module flen_stat_slot #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] in_len,
   input  logic [LEN_W-1:0] out_len,
   input  logic             trunc,
   input  logic             pad,
   input  logic             take,
   output logic             valid,
   output logic [LEN_W-1:0] q_in_len,
   output logic [LEN_W-1:0] q_out_len,
   output logic             q_trunc,
   output logic             q_pad
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         q_in_len  <= '0;
         q_out_len <= '0;
         q_trunc   <= 1'b0;
         q_pad     <= 1'b0;
      end else if (load) begin
         valid     <= 1'b1;
         q_in_len  <= in_len;
         q_out_len <= out_len;
         q_trunc   <= trunc;
         q_pad     <= pad;
      end else if (take) begin
         valid     <= 1'b0;
      end
   end
endmodule

// File: rtl/flen_adjust.sv
module flen_adjust #(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 16,
   parameter int ID_W   = 4,
   parameter int DEST_W = 4,
   parameter int USER_W = 1,
   parameter logic [USER_W-1:0] BAD_VAL  = 1,
   parameter logic [USER_W-1:0] BAD_MASK = 1,
   localparam int KEEP_W = DATA_W / 8,
   localparam int CNT_W  = $clog2(KEEP_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_min_len,
   input  logic [LEN_W-1:0]  cfg_max_len,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic [KEEP_W-1:0] s_tkeep,
   input  logic              s_tvalid,
   output logic              s_tready,
   input  logic              s_tlast,
   input  logic [ID_W-1:0]   s_tid,
   input  logic [DEST_W-1:0] s_tdest,
   input  logic [USER_W-1:0] s_tuser,
   output logic [DATA_W-1:0] m_tdata,
   output logic [KEEP_W-1:0] m_tkeep,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tlast,
   output logic [ID_W-1:0]   m_tid,
   output logic [DEST_W-1:0] m_tdest,
   output logic [USER_W-1:0] m_tuser,
   output logic              st_valid,
   input  logic              st_ready,
   output logic [LEN_W-1:0]  st_in_len,
   output logic [LEN_W-1:0]  st_out_len,
   output logic              st_trunc,
   output logic              st_pad
);
   import flen_pkg::*;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("flen_adjust: DATA_W must be a positive multiple of 8");
   end
   if (LEN_W < CNT_W + 1) begin : g_bad_len
      $error("flen_adjust: LEN_W too small for the lane count");
   end

   flen_state_e      state_q;
   logic [LEN_W-1:0] cnt_in_q, cnt_out_q, min_q, max_q;
   logic             first_q, bad_q;
   logic [ID_W-1:0]   id_q;
   logic [DEST_W-1:0] dest_q;
   logic [USER_W-1:0] user_q;

   logic [CNT_W-1:0]  nb;
   logic [LEN_W-1:0]  eff_min, eff_max;
   logic [LEN_W:0]    new_len;
   logic [KEEP_W-1:0] mask_min, mask_max;
   logic              beat_bad, cut, padneed, pad_done_here, pad_last;
   logic              stat_busy, ends, hold, s_fire, m_fire;
   logic              ld, ld_tr, ld_pd;
   logic [LEN_W-1:0]  ld_in, ld_out;

   flen_keep_count #(.KEEP_W(KEEP_W)) i_cnt (.keep(s_tkeep), .count(nb));

   flen_lane_mask #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) i_mask_min (
      .base(cnt_out_q), .limit(eff_min), .mask(mask_min));
   flen_lane_mask #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) i_mask_max (
      .base(cnt_out_q), .limit(eff_max), .mask(mask_max));

   flen_stat_slot #(.LEN_W(LEN_W)) i_stat (
      .clk(clk), .rst_n(rst_n), .load(ld), .in_len(ld_in), .out_len(ld_out),
      .trunc(ld_tr), .pad(ld_pd), .take(st_ready), .valid(st_valid),
      .q_in_len(st_in_len), .q_out_len(st_out_len), .q_trunc(st_trunc),
      .q_pad(st_pad));

   if (BAD_MASK == '0) begin : g_no_bad
      assign beat_bad = 1'b0;
   end else begin : g_bad
      assign beat_bad = ((s_tuser ^ BAD_VAL) & BAD_MASK) == '0;
   end

   assign eff_min       = first_q ? cfg_min_len : min_q;
   assign eff_max       = first_q ? cfg_max_len : max_q;
   assign new_len       = {1'b0, cnt_out_q} + (LEN_W+1)'(nb);
   assign cut           = (new_len > {1'b0, eff_max}) ||
                          (new_len == {1'b0, eff_max} && !s_tlast);
   assign padneed       = s_tlast && !cut && (new_len < {1'b0, eff_min});
   assign pad_done_here = ({1'b0, cnt_out_q} + (LEN_W+1)'(KEEP_W)) >= {1'b0, eff_min};
   assign pad_last      = pad_done_here;
   assign stat_busy     = st_valid && !st_ready;
   assign s_fire        = s_tvalid && s_tready;
   assign m_fire        = m_tvalid && m_tready;

   always_comb begin
      ends     = 1'b0;
      hold     = 1'b0;
      s_tready = 1'b0;
      m_tvalid = 1'b0;
      m_tdata  = s_tdata;
      m_tkeep  = s_tkeep;
      m_tlast  = s_tlast;
      m_tid    = s_tid;
      m_tdest  = s_tdest;
      m_tuser  = s_tuser;
      ld       = 1'b0;
      ld_in    = new_len[LEN_W-1:0];
      ld_out   = new_len[LEN_W-1:0];
      ld_tr    = 1'b0;
      ld_pd    = 1'b0;
      case (state_q)
         ST_PASS: begin
            ends     = s_tlast && !(padneed && !pad_done_here);
            hold     = ends && stat_busy;
            m_tvalid = s_tvalid && !hold;
            s_tready = m_tready && !hold;
            m_tlast  = cut || ends;
            if (cut) begin
               m_tkeep = s_tkeep & mask_max;
               if (bad_q || beat_bad)
                  m_tuser = (s_tuser & ~BAD_MASK) | (BAD_VAL & BAD_MASK);
            end else if (padneed) begin
               m_tkeep = s_tkeep | mask_min;
               for (int i = 0; i < KEEP_W; i++)
                  if (!s_tkeep[i]) m_tdata[8*i +: 8] = 8'h00;
            end
            ld     = s_fire && ends;
            ld_out = cut ? eff_max : (padneed ? eff_min : new_len[LEN_W-1:0]);
            ld_tr  = cut;
            ld_pd  = padneed;
         end
         ST_DROP: begin
            s_tready = !(s_tlast && stat_busy);
            ld       = s_fire && s_tlast;
            ld_in    = cnt_in_q + LEN_W'(nb);
            ld_out   = cnt_out_q;
            ld_tr    = 1'b1;
         end
         default: begin
            m_tvalid = !(pad_last && stat_busy);
            m_tdata  = '0;
            m_tkeep  = mask_min;
            m_tlast  = pad_last;
            m_tid    = id_q;
            m_tdest  = dest_q;
            m_tuser  = user_q;
            ld       = m_fire && pad_last;
            ld_in    = cnt_in_q;
            ld_out   = min_q;
            ld_pd    = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_PASS;
         cnt_in_q  <= '0;
         cnt_out_q <= '0;
         min_q     <= '0;
         max_q     <= '0;
         first_q   <= 1'b1;
         bad_q     <= 1'b0;
         id_q      <= '0;
         dest_q    <= '0;
         user_q    <= '0;
      end else if (ld) begin
         state_q   <= ST_PASS;
         cnt_in_q  <= '0;
         cnt_out_q <= '0;
         first_q   <= 1'b1;
         bad_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_PASS: if (s_fire) begin
               first_q <= 1'b0;
               if (first_q) begin
                  min_q <= cfg_min_len;
                  max_q <= cfg_max_len;
               end
               bad_q    <= bad_q || beat_bad;
               cnt_in_q <= new_len[LEN_W-1:0];
               if (cut) begin
                  cnt_out_q <= eff_max;
                  state_q   <= ST_DROP;
               end else if (padneed) begin
                  cnt_out_q <= cnt_out_q + LEN_W'(KEEP_W);
                  id_q      <= s_tid;
                  dest_q    <= s_tdest;
                  user_q    <= s_tuser;
                  state_q   <= ST_PAD;
               end else begin
                  cnt_out_q <= new_len[LEN_W-1:0];
               end
            end
            ST_DROP: if (s_fire) cnt_in_q <= cnt_in_q + LEN_W'(nb);
            default: if (m_fire) cnt_out_q <= cnt_out_q + LEN_W'(KEEP_W);
         endcase
      end
   end
endmodule

// File: rtl/flen_adjust_chk.sv
module flen_adjust_chk #(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 16,
   localparam int KEEP_W = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] m_tdata,
   input logic [KEEP_W-1:0] m_tkeep,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic              s_tready,
   input logic              st_valid,
   input logic              st_ready,
   input logic [LEN_W-1:0]  st_in_len,
   input logic [LEN_W-1:0]  st_out_len,
   input logic              st_trunc,
   input logic              st_pad
);
   p_trunc_longer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_trunc |-> st_in_len > st_out_len);
   p_pad_shorter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_pad |-> st_in_len < st_out_len);
   p_equal_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && !st_trunc && !st_pad |-> st_in_len == st_out_len);
   p_stat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && !st_ready |=> st_valid && $stable(st_in_len) &&
      $stable(st_out_len) && $stable(st_trunc) && $stable(st_pad));
   p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && m_tready && !s_tready |-> m_tdata == '0);
   p_keep_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (KEEP_W'(m_tkeep + 1'b1) & m_tkeep) == '0);
endmodule

bind flen_adjust flen_adjust_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_flen_adjust.sv
module test_flen_adjust;
   localparam int DW = 16, LW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [LW-1:0] cfg_min = '0, cfg_max = 16'd100;
   logic [DW-1:0] s_tdata = '0;
   logic [1:0] s_tkeep = '0;
   logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
   logic [3:0] s_tid = '0, s_tdest = '0;
   logic [0:0] s_tuser = '0;
   logic [DW-1:0] m_tdata;
   logic [1:0] m_tkeep;
   logic m_tvalid, m_tlast, m_tready;
   logic [3:0] m_tid, m_tdest;
   logic [0:0] m_tuser;
   logic st_valid, st_ready = 1'b1, st_trunc, st_pad;
   logic [LW-1:0] st_in_len, st_out_len;

   logic bp_en = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   int errors = 0, checks = 0, cyc = 0;
   int seed = 0;

   logic [7:0] out_b[$];
   int n_last;
   logic [0:0] last_user;
   logic [3:0] last_id, last_dest;
   int st_in[$], st_out[$];
   logic st_tr[$], st_pd[$];

   always #5 clk = ~clk;

   flen_adjust #(.DATA_W(DW), .LEN_W(LW)) i_flen_adjust (
      .clk(clk), .rst_n(rst_n), .cfg_min_len(cfg_min), .cfg_max_len(cfg_max),
      .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .s_tlast(s_tlast), .s_tid(s_tid), .s_tdest(s_tdest), .s_tuser(s_tuser),
      .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid), .m_tready(m_tready),
      .m_tlast(m_tlast), .m_tid(m_tid), .m_tdest(m_tdest), .m_tuser(m_tuser),
      .st_valid(st_valid), .st_ready(st_ready), .st_in_len(st_in_len),
      .st_out_len(st_out_len), .st_trunc(st_trunc), .st_pad(st_pad));

   assign m_tready = bp_en ? lfsr[0] : 1'b1;

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (m_tvalid && m_tready) begin
         for (int i = 0; i < 2; i++)
            if (m_tkeep[i]) out_b.push_back(m_tdata[8*i +: 8]);
         if (m_tlast) begin
            n_last++;
            last_user = m_tuser;
            last_id = m_tid;
            last_dest = m_tdest;
         end
      end
      if (st_valid && st_ready) begin
         st_in.push_back(int'(st_in_len));
         st_out.push_back(int'(st_out_len));
         st_tr.push_back(st_trunc);
         st_pd.push_back(st_pad);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      out_b.delete(); st_in.delete(); st_out.delete(); st_tr.delete(); st_pd.delete();
      n_last = 0;
   endtask

   // drive one frame of len bytes, byte k = seed+k; bad_beat carries tuser=1
   task automatic send(input int len, input int bad_beat, input int id, input int chg_max);
      int nbeats = (len + 1) / 2;
      @(posedge clk); #1;
      for (int b = 0; b < nbeats; b++) begin
         s_tvalid = 1'b1;
         s_tdata = {8'(seed + 2*b + 1), 8'(seed + 2*b)};
         s_tkeep = (2*b + 1 < len) ? 2'b11 : 2'b01;
         s_tlast = (b == nbeats - 1);
         s_tid = 4'(id);
         s_tdest = 4'(id + 1);
         s_tuser = (b == bad_beat) ? 1'b1 : 1'b0;
         do @(negedge clk); while (!s_tready);
         @(posedge clk); #1;
         if (b == 0 && chg_max >= 0) cfg_max = LW'(chg_max);
      end
      s_tvalid = 1'b0;
      s_tlast = 1'b0;
      s_tuser = 1'b0;
   endtask

   task automatic run(input int len, input int mn, input int mx, input int bad_beat,
                      input int chg_max, input string req);
      int kept, exp_len, bad_cnt;
      bit exp_bad;
      clear_mon();
      seed = seed + 17;
      cfg_min = LW'(mn);
      cfg_max = LW'(mx);
      send(len, bad_beat, 3, chg_max);
      repeat (24) @(posedge clk);
      #1;
      kept = (len > mx) ? mx : len;
      exp_len = (len < mn) ? mn : kept;
      bad_cnt = 0;
      foreach (out_b[k]) begin
         if (out_b[k] !== ((k < kept) ? 8'(seed + k) : 8'h00)) bad_cnt++;
      end
      chk(out_b.size() == exp_len, req, "output byte count", out_b.size(), exp_len);
      chk(bad_cnt == 0, req, "output byte mismatches", bad_cnt, 0);
      chk(n_last == 1, req, "tlast beats", n_last, 1);
      chk(last_id == 4'd3 && last_dest == 4'd4, "R9", "tid/tdest on last beat",
          int'({last_id, last_dest}), int'({4'd3, 4'd4}));
      exp_bad = (bad_beat >= 0) && (len > mx ? (2*bad_beat < kept)
                                               : (bad_beat == (len + 1) / 2 - 1));
      chk(last_user == exp_bad, "R8", "tuser on last beat", int'(last_user), int'(exp_bad));
      chk(st_in.size() == 1, "R4", "status records", st_in.size(), 1);
      if (st_in.size() == 1) begin
         chk(st_in[0] == len, "R4", "status input length", st_in[0], len);
         chk(st_out[0] == exp_len, "R4", "status output length", st_out[0], exp_len);
         chk(st_tr[0] == (len > mx), "R5", "truncated flag", int'(st_tr[0]), int'(len > mx));
         chk(st_pd[0] == (len < mn), "R5", "padded flag", int'(st_pd[0]), int'(len < mn));
      end
   endtask

   task automatic t_reset();
      #1;
      chk(m_tvalid == 1'b0, "R10", "m_tvalid in reset", int'(m_tvalid), 0);
      chk(st_valid == 1'b0, "R10", "st_valid in reset", int'(st_valid), 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(s_tready == 1'b1 && m_tvalid == 1'b0, "R10", "idle after reset",
          int'({s_tready, m_tvalid}), 2);
   endtask

   task automatic t_stall();
      clear_mon();
      seed = seed + 17;
      cfg_min = 16'd1;
      cfg_max = 16'd20;
      st_ready = 1'b0;
      send(3, -1, 3, -1);
      repeat (4) @(posedge clk);
      fork
         send(1, -1, 3, -1);
         begin
            repeat (5) @(negedge clk);
            chk(s_tvalid && !s_tready, "R7", "final beat stalled", int'(s_tready), 0);
            chk(!m_tvalid, "R7", "no output while stalled", int'(m_tvalid), 0);
            chk(st_valid && st_in_len == 16'd3, "R7", "pending record held",
                int'(st_in_len), 3);
            @(posedge clk); #1 st_ready = 1'b1;
         end
      join
      repeat (6) @(posedge clk);
      #1;
      chk(st_in.size() == 2, "R7", "records after release", st_in.size(), 2);
      if (st_in.size() == 2) begin
         chk(st_in[0] == 3, "R7", "first record input length", st_in[0], 3);
         chk(st_in[1] == 1, "R7", "second record input length", st_in[1], 1);
      end
      chk(out_b.size() == 4, "R7", "bytes of both frames", out_b.size(), 4);
   endtask

   initial begin
      t_reset();
      run(7, 4, 20, -1, -1, "R1");       // in range, odd
      run(8, 8, 8, 3, -1, "R1");         // exactly at both limits, bad on last passes
      run(3, 9, 20, -1, -1, "R2");       // pad over several beats
      run(1, 2, 20, -1, -1, "R2");       // pad inside the last input beat
      run(12, 0, 5, 0, -1, "R3");        // cut mid-beat, bad seen before cut
      run(7, 0, 6, -1, -1, "R3");        // cut on beat boundary, no bad
      run(12, 0, 5, 5, -1, "R3");        // bad only in dropped part
      run(8, 0, 20, -1, 3, "R6");        // max lowered mid-frame, ignored
      bp_en = 1'b1;
      run(3, 11, 20, -1, -1, "R2");      // pad under back-pressure
      run(13, 0, 9, -1, -1, "R3");       // cut under back-pressure
      bp_en = 1'b0;
      t_stall();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule